// File: doc/BRIEF.md
# Programmable SCL Phase Timing Generator

This block paces the serial clock of a two-wire bus master. It divides the system clock into prescaled ticks. It then walks through the phases of a transfer: start condition, data bits, repeated start and stop. Each phase lasts a programmed number of ticks. At the points where the bus sequencer must act, the block emits single-cycle strobes, and it drives the SCL level that matches the current phase.

Two sets of timing words are held, one for fast mode and one for high-speed mode, and `hs_sel` picks between them. Each bit period carries a fixed overhead, counted in plain system clocks, that models the input synchronizer and the glitch filter. A framing bit `run` drives the block. The sequencer raises it to open a transfer and clears it to finish with a stop. It holds `rs_req` high to insert a repeated start. Timing words may be rewritten at any time. They are copied into a working set only when a transfer opens and at the start of each bit, so a phase that is running never changes length.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and for as long as `run` stays low, `scl_o` is high, `busy` is low and every strobe is low.
- R2: One tick is DIV+1 system clocks. A phase whose count is N lasts (N+1)(DIV+1) clocks. `start_stb` fires (SSU+1)(DIV+1) cycles after the clock edge that first samples `run` high.
- R3: The first `sample_stb` after a `start_stb` follows it by (SHD+LO+HI+3)(DIV+1) cycles.
- R4: Consecutive `sample_stb` pulses with unchanged settings are (DIV+1)(LO+HI+2) + 8 + 2·FLT cycles apart, where FLT is `flt_cyc`. With parameter FLT_DOUBLE = 0 the filter term is 1·FLT.
- R5: `setup_stb` fires once in each SCL-low phase, at the last clock of tick index C. C = min(DHD, LO−DSU) when LO ≥ DSU, and 0 otherwise. SCL is low at that point, so `sample_stb` follows by (LO−C+HI+1)(DIV+1) cycles.
- R6: `sample_stb` marks the last clock of the SCL-high phase, and `scl_o` is high there.
- R7: If `run` is low at the end of a bit's overhead, `stop_stb` follows that bit's `sample_stb` by OVH + (PSU+1)(DIV+1) cycles, where OVH = 8 + 2·FLT. The cycle after that, `busy` is low.
- R8: If `run` and `rs_req` are both high at the end of a bit's overhead, SCL is held low for (SRL+1)(DIV+1) cycles, then a new start setup runs. The next `start_stb` follows the bit's `sample_stb` by OVH + (SRL+1)(DIV+1) + (SSU+1)(DIV+1) cycles.
- R9: `hs_sel` = 1 selects the high-speed words and 0 selects the fast words. Word 1: SSU [31:24], SHD [23:16], PSU [15:8]. Word 2: DSU [31:24], LO [15:8], HI [7:0]. Word 3: DIV [23:16], SRL [7:0]. The shared hold word: DHD [7:0]. All other bits are ignored.
- R10: Changes to the words, to `hs_sel` or to `flt_cyc` take effect only at the next bit start. The overhead after a bit uses the FLT captured when that bit started.
- R11: At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| run | input | 1 | Opens a transfer when high; a stop follows once low |
| rs_req | input | 1 | Requests a repeated start at the next bit end |
| hs_sel | input | 1 | Selects the high-speed timing set |
| flt_cyc | input | 3 | Glitch-filter cycle count |
| fs_w1 | input | 32 | Fast set: start setup, start hold, stop setup |
| fs_w2 | input | 32 | Fast set: data setup, SCL low, SCL high |
| fs_w3 | input | 32 | Fast set: divider, repeated-start release |
| hs_w1 | input | 32 | High-speed set, layout as fs_w1 |
| hs_w2 | input | 32 | High-speed set, layout as fs_w2 |
| hs_w3 | input | 32 | High-speed set, layout as fs_w3 |
| dhold_w | input | 32 | Data hold count in bits 7:0, shared by both sets |
| scl_o | output | 1 | SCL level for the current phase |
| busy | output | 1 | High whenever the generator is not idle |
| start_stb | output | 1 | Point where SDA falls for a start |
| stop_stb | output | 1 | Point where SDA rises for a stop |
| setup_stb | output | 1 | Point where the next data bit may be driven |
| sample_stb | output | 1 | Point where the received bit is taken |

## Verification
The hardest case to reach is a timing rewrite that lands inside a running bit. It has to show the old value in the bit that is running, a mix of old and new in the next interval (old overhead, new low time), and only new values after that. The bench reaches it by counting cycles from an observed `sample_stb` and rewriting the words a few cycles into the following low phase. The repeated-start path is reached the same way: `rs_req` is held across a bit end, and SCL is probed in the first release cycle. Random frames draw settings for both sets, select one at random and fill the unused bits with junk. Directed frames cover a divider of 255 and the all-zero counts.

// File: rtl/sclt_pkg.sv
package sclt_pkg;
  localparam int CNT_W    = 8;
  localparam int FLT_W    = 3;
  localparam int OVH_BASE = 8;
  localparam int OVH_W    = 5;
  localparam int NSETS    = 2;

  // field positions inside the timing words
  localparam int W1_SSU_LSB = 24;
  localparam int W1_SHD_LSB = 16;
  localparam int W1_PSU_LSB = 8;
  localparam int W2_DSU_LSB = 24;
  localparam int W2_LO_LSB  = 8;
  localparam int W2_HI_LSB  = 0;
  localparam int W3_DIV_LSB = 16;
  localparam int W3_SRL_LSB = 0;
  localparam int WH_DHD_LSB = 0;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ST_SU,
    PH_ST_HD,
    PH_LOW,
    PH_HIGH,
    PH_OVH,
    PH_SP_SU,
    PH_SR_REL
  } sclt_ph_e;

  typedef struct packed {
    logic [CNT_W-1:0] st_su;
    logic [CNT_W-1:0] st_hd;
    logic [CNT_W-1:0] sp_su;
    logic [CNT_W-1:0] d_su;
    logic [CNT_W-1:0] d_hd;
    logic [CNT_W-1:0] scl_lo;
    logic [CNT_W-1:0] scl_hi;
    logic [CNT_W-1:0] div;
    logic [CNT_W-1:0] sr_rel;
    logic [OVH_W-1:0] ovh;
    logic [CNT_W-1:0] chg;
  } sclt_cfg_t;

  // tick index inside the low phase where new data may be driven
  function automatic logic [CNT_W-1:0] chg_point(
    input logic [CNT_W-1:0] lo,
    input logic [CNT_W-1:0] su,
    input logic [CNT_W-1:0] hd
  );
    logic [CNT_W-1:0] room;
    if (lo < su) begin
      return '0;
    end
    room = lo - su;
    return (hd < room) ? hd : room;
  endfunction
endpackage

// File: rtl/sclt_cfg_latch.sv
module sclt_cfg_latch
  import sclt_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FLT_DOUBLE = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic                          hs_sel_i,
  input  logic [FLT_W-1:0]              flt_i,
  input  logic [NSETS-1:0][WORD_W-1:0]  w1_i,
  input  logic [NSETS-1:0][WORD_W-1:0]  w2_i,
  input  logic [NSETS-1:0][WORD_W-1:0]  w3_i,
  input  logic [WORD_W-1:0]             dhold_i,
  output sclt_cfg_t                     cfg_o
);
  sclt_cfg_t        dec [NSETS];
  sclt_cfg_t        sel_cfg;
  sclt_cfg_t        cfg_nx;
  sclt_cfg_t        cfg_q;
  logic [OVH_W-1:0] flt_term;
  logic [OVH_W-1:0] ovh_w;

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    assign dec[g] = '{
      st_su:  w1_i[g][W1_SSU_LSB +: CNT_W],
      st_hd:  w1_i[g][W1_SHD_LSB +: CNT_W],
      sp_su:  w1_i[g][W1_PSU_LSB +: CNT_W],
      d_su:   w2_i[g][W2_DSU_LSB +: CNT_W],
      d_hd:   dhold_i[WH_DHD_LSB +: CNT_W],
      scl_lo: w2_i[g][W2_LO_LSB +: CNT_W],
      scl_hi: w2_i[g][W2_HI_LSB +: CNT_W],
      div:    w3_i[g][W3_DIV_LSB +: CNT_W],
      sr_rel: w3_i[g][W3_SRL_LSB +: CNT_W],
      ovh:    '0,
      chg:    '0
    };
  end

  if (FLT_DOUBLE != 0) begin : g_flt_x2
    assign flt_term = OVH_W'({flt_i, 1'b0});
  end else begin : g_flt_x1
    assign flt_term = OVH_W'(flt_i);
  end

  assign ovh_w = OVH_W'(OVH_BASE) + flt_term;

  always_comb begin
    sel_cfg     = dec[hs_sel_i];
    sel_cfg.ovh = ovh_w;
    sel_cfg.chg = chg_point(sel_cfg.scl_lo, sel_cfg.d_su, sel_cfg.d_hd);
    cfg_nx      = load_i ? sel_cfg : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_nx;
    end
  end

  assign cfg_o = cfg_q;

  AST_OVH_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_i) |-> cfg_q.ovh >= OVH_W'(OVH_BASE)) else $error("ovh below base"); // R4
endmodule

// File: rtl/sclt_prescaler.sv
module sclt_prescaler
  import sclt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] pre_nx;

  assign tick_o = en_i && (pre_q == div_i);

  always_comb begin
    if (clr_i || !en_i || tick_o) begin
      pre_nx = '0;
    end else begin
      pre_nx = pre_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_nx;
    end
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> pre_q <= div_i) else $error("prescaler past divider"); // R2
endmodule

// File: rtl/sclt_phase_seq.sv
module sclt_phase_seq
  import sclt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_i,
  input  logic      rs_req_i,
  input  sclt_cfg_t cfg_i,
  input  logic      tick_i,
  output logic      tick_en_o,
  output logic      pre_clr_o,
  output logic      load_o,
  output logic      scl_o,
  output logic      busy_o,
  output logic      start_stb_o,
  output logic      stop_stb_o,
  output logic      setup_stb_o,
  output logic      sample_stb_o
);
  sclt_ph_e         st_q, st_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] ovh_last;
  logic             tick_ph;
  logic             done;
  logic             adv;

  always_comb begin
    unique case (st_q)
      PH_ST_SU:  lim = cfg_i.st_su;
      PH_ST_HD:  lim = cfg_i.st_hd;
      PH_LOW:    lim = cfg_i.scl_lo;
      PH_HIGH:   lim = cfg_i.scl_hi;
      PH_SP_SU:  lim = cfg_i.sp_su;
      PH_SR_REL: lim = cfg_i.sr_rel;
      default:   lim = '0;
    endcase
    tick_ph  = st_q inside {PH_ST_SU, PH_ST_HD, PH_LOW, PH_HIGH, PH_SP_SU, PH_SR_REL};
    ovh_last = CNT_W'(cfg_i.ovh - OVH_W'(1));
    if (tick_ph) begin
      done = tick_i && (cnt_q == lim);
      adv  = tick_i;
    end else begin
      done = (st_q == PH_OVH) && (cnt_q == ovh_last);
      adv  = (st_q == PH_OVH);
    end
  end

  always_comb begin
    st_nx  = st_q;
    load_o = 1'b0;
    unique case (st_q)
      PH_IDLE: begin
        if (run_i) begin
          st_nx  = PH_ST_SU;
          load_o = 1'b1;
        end
      end
      PH_ST_SU:  if (done) st_nx = PH_ST_HD;
      PH_ST_HD: begin
        if (done) begin
          st_nx  = PH_LOW;
          load_o = 1'b1;
        end
      end
      PH_LOW:    if (done) st_nx = PH_HIGH;
      PH_HIGH:   if (done) st_nx = PH_OVH;
      PH_OVH: begin
        if (done) begin
          if (!run_i) begin
            st_nx = PH_SP_SU;
          end else if (rs_req_i) begin
            st_nx = PH_SR_REL;
          end else begin
            st_nx  = PH_LOW;
            load_o = 1'b1;
          end
        end
      end
      PH_SP_SU:  if (done) st_nx = PH_IDLE;
      PH_SR_REL: if (done) st_nx = PH_ST_SU;
      default:   st_nx = PH_IDLE;
    endcase

    if (st_nx != st_q) begin
      cnt_nx = '0;
    end else if (adv) begin
      cnt_nx = cnt_q + CNT_W'(1);
    end else begin
      cnt_nx = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_nx;
      cnt_q <= cnt_nx;
    end
  end

  assign tick_en_o    = tick_ph;
  assign pre_clr_o    = (st_nx != st_q) || (st_q == PH_IDLE);
  assign scl_o        = !(st_q inside {PH_LOW, PH_SR_REL});
  assign busy_o       = (st_q != PH_IDLE);
  assign start_stb_o  = (st_q == PH_ST_SU) && done;
  assign stop_stb_o   = (st_q == PH_SP_SU) && done;
  assign sample_stb_o = (st_q == PH_HIGH) && done;
  assign setup_stb_o  = (st_q == PH_LOW) && tick_i && (cnt_q == cfg_i.chg);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tick_ph |-> cnt_q <= lim) else $error("phase count past limit"); // R2
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_stb_o, stop_stb_o, setup_stb_o, sample_stb_o})) else $error("strobes overlap"); // R11
  AST_SETUP_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    setup_stb_o |-> !scl_o) else $error("setup while scl high"); // R5
  AST_SAMPLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb_o |=> scl_o) else $error("scl dropped after sample"); // R6
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb_o |=> !busy_o) else $error("busy after stop"); // R7
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_LOW && $past(st_q) == PH_LOW) |-> $stable(cfg_i)) else $error("cfg moved mid phase"); // R10
  AST_RESTART_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_SR_REL && $past(st_q) == PH_OVH) |-> $past(rs_req_i)) else $error("release without request"); // R8
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import sclt_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FLT_DOUBLE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rs_req,
  input  logic              hs_sel,
  input  logic [FLT_W-1:0]  flt_cyc,
  input  logic [WORD_W-1:0] fs_w1,
  input  logic [WORD_W-1:0] fs_w2,
  input  logic [WORD_W-1:0] fs_w3,
  input  logic [WORD_W-1:0] hs_w1,
  input  logic [WORD_W-1:0] hs_w2,
  input  logic [WORD_W-1:0] hs_w3,
  input  logic [WORD_W-1:0] dhold_w,
  output logic              scl_o,
  output logic              busy,
  output logic              start_stb,
  output logic              stop_stb,
  output logic              setup_stb,
  output logic              sample_stb
);
  logic [NSETS-1:0][WORD_W-1:0] w1, w2, w3;
  sclt_cfg_t cfg;
  logic      load;
  logic      tick;
  logic      tick_en;
  logic      pre_clr;

  assign w1 = {hs_w1, fs_w1};
  assign w2 = {hs_w2, fs_w2};
  assign w3 = {hs_w3, fs_w3};

  sclt_cfg_latch #(
    .WORD_W     (WORD_W),
    .FLT_DOUBLE (FLT_DOUBLE)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .hs_sel_i (hs_sel),
    .flt_i    (flt_cyc),
    .w1_i     (w1),
    .w2_i     (w2),
    .w3_i     (w3),
    .dhold_i  (dhold_w),
    .cfg_o    (cfg)
  );

  sclt_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (tick_en),
    .clr_i  (pre_clr),
    .div_i  (cfg.div),
    .tick_o (tick)
  );

  sclt_phase_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run),
    .rs_req_i     (rs_req),
    .cfg_i        (cfg),
    .tick_i       (tick),
    .tick_en_o    (tick_en),
    .pre_clr_o    (pre_clr),
    .load_o       (load),
    .scl_o        (scl_o),
    .busy_o       (busy),
    .start_stb_o  (start_stb),
    .stop_stb_o   (stop_stb),
    .setup_stb_o  (setup_stb),
    .sample_stb_o (sample_stb)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(setup_stb || sample_stb || stop_stb)) else $error("strobe while idle"); // R1
endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
  typedef struct {
    int su, hd, sp, dsu, dhd, lo, hi, dv, sr;
  } tcfg_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run, rs_req, hs_sel;
  logic [2:0]  flt_cyc;
  logic [31:0] fs_w1, fs_w2, fs_w3, hs_w1, hs_w2, hs_w3, dhold_w;
  logic        scl_o, busy, start_stb, stop_stb, setup_stb, sample_stb;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  logic  scl_seen;
  tcfg_t cf [2];
  int    flt;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .rs_req(rs_req), .hs_sel(hs_sel),
    .flt_cyc(flt_cyc), .fs_w1(fs_w1), .fs_w2(fs_w2), .fs_w3(fs_w3),
    .hs_w1(hs_w1), .hs_w2(hs_w2), .hs_w3(hs_w3), .dhold_w(dhold_w),
    .scl_o(scl_o), .busy(busy), .start_stb(start_stb), .stop_stb(stop_stb),
    .setup_stb(setup_stb), .sample_stb(sample_stb)
  );

  function automatic int ph(input int n, input int d);
    return (n + 1) * (d + 1);
  endfunction
  function automatic int ovh_of(input int f);
    return 8 + 2 * f;
  endfunction
  function automatic int period(input tcfg_t c, input int f);
    return (c.lo + c.hi + 2) * (c.dv + 1) + ovh_of(f);
  endfunction
  function automatic int chg_of(input tcfg_t c);
    if (c.lo < c.dsu) return 0;
    return (c.dhd < c.lo - c.dsu) ? c.dhd : c.lo - c.dsu;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ev(input int which, input string tag, output int t);
    bit hit = 1'b0;
    t = -1;
    for (int i = 0; i < 6000 && !hit; i++) begin
      @(negedge clk);
      case (which)
        0: hit = start_stb;
        1: hit = stop_stb;
        2: hit = setup_stb;
        default: hit = sample_stb;
      endcase
    end
    if (hit) begin
      t = cyc;
      scl_seen = scl_o;
    end else begin
      checks++;
      errors++;
      $display("FAIL %s strobe %0d missing actual=none expected=pulse", tag, which);
    end
  endtask

  task automatic program_regs();
    fs_w1 = {8'(cf[0].su), 8'(cf[0].hd), 8'(cf[0].sp), 8'($urandom)};
    fs_w2 = {8'(cf[0].dsu), 8'($urandom), 8'(cf[0].lo), 8'(cf[0].hi)};
    fs_w3 = {8'($urandom), 8'(cf[0].dv), 8'($urandom), 8'(cf[0].sr)};
    hs_w1 = {8'(cf[1].su), 8'(cf[1].hd), 8'(cf[1].sp), 8'($urandom)};
    hs_w2 = {8'(cf[1].dsu), 8'($urandom), 8'(cf[1].lo), 8'(cf[1].hi)};
    hs_w3 = {8'($urandom), 8'(cf[1].dv), 8'($urandom), 8'(cf[1].sr)};
    dhold_w = {24'($urandom), 8'(cf[0].dhd)};
    flt_cyc = 3'(flt);
  endtask

  function automatic tcfg_t rand_cfg(input int dhd);
    tcfg_t c;
    c.su = $urandom_range(0, 5); c.hd = $urandom_range(0, 5);
    c.sp = $urandom_range(0, 5); c.sr = $urandom_range(0, 5);
    c.dsu = $urandom_range(0, 7); c.dhd = dhd;
    c.lo = $urandom_range(0, 7); c.hi = $urandom_range(0, 7);
    c.dv = $urandom_range(0, 3);
    return c;
  endfunction

  // full frame: start, two bits, stop
  task automatic do_frame(input int s);
    tcfg_t c = cf[s];
    int t0, ts, tu, tp, tp2, tq;
    @(negedge clk);
    hs_sel = s[0];
    run = 1'b1;
    t0 = cyc;
    wait_ev(0, "R2", ts);
    check("R2 start delay", ts - t0, ph(c.su, c.dv));
    wait_ev(2, "R5", tu);
    check("R5 scl low at setup", scl_seen, 0);
    wait_ev(3, "R3", tp);
    check("R3 start to first sample", tp - ts, (c.hd + c.lo + c.hi + 3) * (c.dv + 1));
    check("R5 setup to sample", tp - tu, (c.lo - chg_of(c) + c.hi + 1) * (c.dv + 1));
    check("R6 scl high at sample", scl_seen, 1);
    wait_ev(3, "R4", tp2);
    check("R4 bit period R9 set select", tp2 - tp, period(c, flt));
    run = 1'b0;
    wait_ev(1, "R7", tq);
    check("R7 stop delay", tq - tp2, ovh_of(flt) + ph(c.sp, c.dv));
    @(negedge clk);
    check("R7 idle after stop", busy, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, ts, tp, tp2, tp3, tp4, tq, old_flt;
    void'($urandom(32'd4711));
    rst_n = 1'b0; run = 1'b0; rs_req = 1'b0; hs_sel = 1'b0;
    cf[0] = rand_cfg(2); cf[1] = rand_cfg(2); flt = 0;
    program_regs();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 scl after reset", scl_o, 1);
    check("R1 busy after reset", busy, 0);
    check("R1 strobes after reset", {start_stb, stop_stb, setup_stb, sample_stb}, 0);
    repeat (20) @(negedge clk);
    check("R1 idle with run low", {busy, scl_o, start_stb, stop_stb, setup_stb, sample_stb}, 6'b010000);

    // R9 directed: distinct sets
    cf[0] = '{su:1, hd:1, sp:1, dsu:1, dhd:1, lo:2, hi:1, dv:1, sr:1};
    cf[1] = '{su:0, hd:0, sp:0, dsu:0, dhd:1, lo:6, hi:4, dv:0, sr:0};
    flt = 3;
    program_regs();
    do_frame(1);
    do_frame(0);

    // R2 R4 boundary: divider 255, zero counts, max filter
    cf[0] = '{su:0, hd:0, sp:0, dsu:0, dhd:0, lo:0, hi:0, dv:255, sr:0};
    flt = 7;
    program_regs();
    do_frame(0);
    // all-zero with divider 0
    cf[0] = '{su:0, hd:0, sp:0, dsu:0, dhd:0, lo:0, hi:0, dv:0, sr:0};
    flt = 0;
    program_regs();
    do_frame(0);

    // R10 rewrite inside a running low phase
    cf[0] = '{su:1, hd:1, sp:2, dsu:1, dhd:2, lo:5, hi:2, dv:1, sr:1};
    flt = 1;
    program_regs();
    @(negedge clk);
    hs_sel = 1'b0; run = 1'b1;
    wait_ev(0, "R10", ts);
    wait_ev(3, "R10", tp);
    repeat (ovh_of(flt) + 3) @(negedge clk);
    old_flt = flt;
    cf[0].lo = 1; flt = 4;
    program_regs();
    wait_ev(3, "R10", tp2);
    check("R10 running bit keeps old", tp2 - tp, (5 + 2 + 2) * 2 + ovh_of(old_flt));
    wait_ev(3, "R10", tp3);
    check("R10 old ovh new low", tp3 - tp2, ovh_of(old_flt) + (1 + 2 + 2) * 2);
    wait_ev(3, "R10", tp4);
    check("R10 all new", tp4 - tp3, period(cf[0], flt));
    run = 1'b0;
    wait_ev(1, "R10", tq);
    check("R10 stop new ovh", tq - tp4, ovh_of(flt) + ph(cf[0].sp, cf[0].dv));

    // R8 repeated start
    cf[0] = '{su:2, hd:1, sp:1, dsu:0, dhd:1, lo:3, hi:2, dv:2, sr:3};
    flt = 2;
    program_regs();
    @(negedge clk);
    run = 1'b1;
    wait_ev(0, "R8", ts);
    rs_req = 1'b1;
    wait_ev(3, "R8", tp);
    repeat (ovh_of(flt) + 1) @(negedge clk);
    check("R8 scl low in release", scl_o, 0);
    wait_ev(0, "R8", t0);
    check("R8 restart delay", t0 - tp, ovh_of(flt) + ph(cf[0].sr, cf[0].dv) + ph(cf[0].su, cf[0].dv));
    rs_req = 1'b0;
    wait_ev(3, "R8", tp2);
    check("R3 sample after restart", tp2 - t0, (1 + 3 + 2 + 3) * 3);
    run = 1'b0;
    wait_ev(1, "R7", tq);
    check("R7 stop after restart", tq - tp2, ovh_of(flt) + ph(cf[0].sp, cf[0].dv));

    // random frames over both sets
    for (int k = 0; k < 20; k++) begin
      int s = $urandom_range(0, 1);
      int dh = $urandom_range(0, 7);
      cf[0] = rand_cfg(dh);
      cf[1] = rand_cfg(dh);
      flt = $urandom_range(0, 7);
      program_regs();
      do_frame(s);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule